// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block moves a list of registers to or from a memory stack with one memory transfer per list entry. The caller gives a 32-bit selection mask, a direction and a start pulse. The sequencer then walks the mask and issues word transfers on a simple request/ready memory port. It keeps a working copy of the stack pointer and writes every updated value back. In a push it reads general registers and the status word. In a pop it writes them back. It raises `done` once the whole list has been moved.

Mask bit 31 selects the status word and bits 30 down to 0 select general registers 30 down to 0. A push and a pop with the same mask mirror each other. A push stores the status word first, and a pop restores it last and only in its lower half. A push followed by a pop with the same mask therefore brings the general registers back. The general register file and the status word live outside the block. The block reaches them through a registered read address with one cycle of read latency and through registered write strobes.

Top module: `regstack_seq`

## Requirements
- R1: While and after a synchronous reset, `busy`, `done` and `mem_req` are low.
- R2: Push (`op_pop`=0). If mask bit 31 is set, the stack pointer first drops by 4 and the whole 32-bit status word is written at the new value. Then, for each set bit from index 30 down to 0, the stack pointer drops by 4 and that register is written there.
- R3: Pop (`op_pop`=1). For each set bit from index 0 up to 30, the register is loaded from the current stack pointer and the stack pointer then rises by 4.
- R4: On pop, the status word is transferred after all general registers when mask bit 31 is set. That read is flagged with `mem_half`=1, and only its low 16 bits replace the low half of the status word. The upper 16 bits are kept and the stack pointer rises by 4.
- R5: Register-file write addresses are always 0 to 30, and mask bit 31 never selects a general register.
- R6: Clear mask bits cost no memory cycle. The number of transfers equals the number of set mask bits.
- R7: An all-zero mask raises `done` in the cycle after `start` is sampled. It makes no memory request and leaves the stack pointer unchanged.
- R8: Each request keeps its address, direction and write data stable until `mem_ready` is sampled high, and only one transfer is outstanding.
- R9: `start` is ignored while `busy` is high, and the mask and direction captured at `start` govern the whole operation.
- R10: `done` is a one-cycle pulse. `busy` is low while it is high and no request is pending.
- R11: Each completed transfer pulses `sp_we` one cycle later with the updated stack pointer. The final value equals the start value minus 4 per item on push, or plus 4 per item on pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_pop | input | 1 | 0 = push, 1 = pop |
| mask | input | 32 | Selection list; bit 31 = status word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | Read needs only the low 16 bits |
| mem_addr | output | 32 | Transfer address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data, one cycle after rf_raddr |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| psw_in | input | 32 | Current status word |
| psw_we | output | 1 | Status word write strobe |
| psw_wdata | output | 32 | New status word |
| sp_in | input | 32 | Stack pointer, read at start |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | Updated stack pointer |

## Verification
Two functions can meet at one edge: a new `start` request and the completion of the last memory handshake. The bench provokes this by holding `start` high with a different mask and the opposite direction for the whole run of an operation, so it is present when the final `mem_ready` lands. It releases `start` when `done` appears. The request must be discarded. The transfer log, the restored registers and the final stack pointer must match what the captured mask alone predicts.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;
endpackage

// File: rtl/regstack_pick.sv
// Chooses the next list entry: highest set bit for a push (status word first),
// lowest set bit for a pop (status word last).
module regstack_pick #(
  parameter int MASK_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [MASK_W-1:0] list,
  input  logic              from_top,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = |list;
    idx   = '0;
    if (from_top) begin
      for (int i = 0; i < MASK_W; i++)
        if (list[i]) idx = IDX_W'(i);
    end else begin
      for (int i = MASK_W - 1; i >= 0; i--)
        if (list[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/regstack_step.sv
// Address of the current transfer and stack pointer after it.
module regstack_step #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] sp_cur,
  input  logic              pop,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [ADDR_W-1:0] sp_next
);
  always_comb begin
    if (pop) begin
      xfer_addr = sp_cur;
      sp_next   = sp_cur + ADDR_W'(STEP);
    end else begin
      xfer_addr = sp_cur - ADDR_W'(STEP);
      sp_next   = sp_cur - ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NREG   = 31,
  localparam int MASK_W = NREG + 1,
  localparam int IDX_W  = $clog2(MASK_W),
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_pop,
  input  logic [MASK_W-1:0] mask,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] psw_in,
  output logic              psw_we,
  output logic [DATA_W-1:0] psw_wdata,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wdata
);
  import regstack_pkg::*;

  localparam int STEP   = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;

  seq_state_t        state;
  logic [MASK_W-1:0] list_q;
  logic              pop_q;
  logic [IDX_W-1:0]  cur_q;
  logic [ADDR_W-1:0] sp_q;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic [ADDR_W-1:0] xfer_addr;
  logic [ADDR_W-1:0] sp_next;
  logic              cur_is_status;

  regstack_pick #(.MASK_W(MASK_W), .IDX_W(IDX_W)) pick_i (
    .list     (list_q),
    .from_top (~pop_q),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  regstack_step #(.ADDR_W(ADDR_W), .STEP(STEP)) step_i (
    .sp_cur    (sp_q),
    .pop       (pop_q),
    .xfer_addr (xfer_addr),
    .sp_next   (sp_next)
  );

  assign cur_is_status = (cur_q == IDX_W'(NREG));
  assign sp_wdata      = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      list_q    <= '0;
      pop_q     <= 1'b0;
      cur_q     <= '0;
      sp_q      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_half  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rf_raddr  <= '0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      psw_we    <= 1'b0;
      psw_wdata <= '0;
      sp_we     <= 1'b0;
    end else begin
      done   <= 1'b0;
      rf_we  <= 1'b0;
      psw_we <= 1'b0;
      sp_we  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (mask == '0) begin
              done <= 1'b1;
            end else begin
              list_q <= mask;
              pop_q  <= op_pop;
              sp_q   <= sp_in;
              busy   <= 1'b1;
              state  <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (pick_found) begin
            cur_q    <= pick_idx;
            rf_raddr <= pick_idx[RIDX_W-1:0];
            state    <= ST_ISSUE;
          end else begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= ~pop_q;
          mem_half  <= pop_q & cur_is_status;
          mem_addr  <= xfer_addr;
          mem_wdata <= cur_is_status ? psw_in : rf_rdata;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_ready) begin
            mem_req       <= 1'b0;
            list_q[cur_q] <= 1'b0;
            sp_q          <= sp_next;
            sp_we         <= 1'b1;
            if (pop_q) begin
              if (cur_is_status) begin
                psw_we    <= 1'b1;
                psw_wdata <= {psw_in[DATA_W-1:HALF_W], mem_rdata[HALF_W-1:0]};
              end else begin
                rf_we    <= 1'b1;
                rf_waddr <= cur_q[RIDX_W-1:0];
                rf_wdata <= mem_rdata;
              end
            end
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NREG   = 31,
  localparam int RIDX_W = $clog2(NREG),
  localparam int STEP   = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_half,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_waddr,
  input logic              psw_we,
  input logic              sp_we,
  input logic [ADDR_W-1:0] sp_wdata
);
  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req));

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R2, R11: a push lands the stack pointer on the written address
  p_push_sp_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && mem_we) |=> (sp_we && sp_wdata == $past(mem_addr)));

  // R3, R11: a pop moves the stack pointer one word past the read address
  p_pop_sp_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !mem_we) |=> (sp_we && sp_wdata == $past(mem_addr) + ADDR_W'(STEP)));

  // R4
  p_status_half_r4: assert property (@(posedge clk) disable iff (rst)
    psw_we |-> $past(mem_req && mem_ready && mem_half && !mem_we));

  // R5
  p_rf_index_r5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr < RIDX_W'(NREG)));

  p_single_write_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, psw_we}));

  // R8
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));
endmodule

bind regstack_seq regstack_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) chk_i (.*);

// File: tb/regstack_seq_tb_top.sv
`timescale 1ns/1ps
module regstack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_pop = 1'b0;
  logic [31:0] mask = '0;
  logic        busy, done, mem_req, mem_we, mem_half;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, psw_we, sp_we;
  logic [31:0] psw_wdata, sp_wdata;
  logic [31:0] psw_m, sp_m;
  logic [31:0] rf_m [0:30];
  logic [31:0] mem_m [0:1023];

  int checks = 0;
  int errors = 0;
  int hold_bad = 0;
  int rf_bad = 0;
  int log_n = 0;
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  logic        log_we   [0:63];
  logic        log_half [0:63];
  logic        req_seen = 1'b0;
  logic [31:0] prev_addr, prev_wdata;
  logic        prev_we;

  always #2.5 clk = ~clk;

  regstack_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op_pop(op_pop), .mask(mask),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .psw_in(psw_m), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .sp_in(sp_m), .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  assign rf_rdata = (rf_raddr < 5'd31) ? rf_m[rf_raddr] : 32'hDEAD_BEEF;

  // External state models
  always @(posedge clk) begin
    if (rf_we) begin
      if (rf_waddr < 5'd31) rf_m[rf_waddr] <= rf_wdata;
      else rf_bad++;
    end
    if (psw_we) psw_m <= psw_wdata;
    if (sp_we)  sp_m  <= sp_wdata;
  end

  // Memory responder: decides at the falling edge what the next rising edge sees
  always @(negedge clk) begin
    if (mem_req) begin
      if (req_seen && (mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wdata))
        hold_bad++;
      if ($urandom_range(0, 3) != 0) begin
        if (log_n < 64) begin
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
          log_we[log_n]   = mem_we;
          log_half[log_n] = mem_half;
        end
        log_n++;
        if (mem_we) mem_m[mem_addr[11:2]] = mem_wdata;
        else        mem_rdata = mem_m[mem_addr[11:2]];
        mem_ready = 1'b1;
        req_seen  = 1'b0;
      end else begin
        mem_ready  = 1'b0;
        req_seen   = 1'b1;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wdata = mem_wdata;
      end
    end else begin
      mem_ready = 1'b0;
      req_seen  = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one operation and compares against a model built from the requirements.
  task automatic run_op(input bit pop, input logic [31:0] m, input bit preload, input bit poke);
    logic [31:0] sp0, psw0, a, exp_sp, exp_psw;
    logic [31:0] rf0 [0:30];
    logic [31:0] exp_addr [0:31];
    logic [31:0] exp_data [0:31];
    logic        exp_half [0:31];
    logic [31:0] exp_rf [0:30];
    int n, cyc, bad_ord;
    bit timed_out;
    @(negedge clk);
    if (preload)
      for (int k = 0; k < 40; k++) mem_m[sp_m[11:2] + 10'(k)] = $urandom;
    sp0 = sp_m; psw0 = psw_m;
    for (int i = 0; i < 31; i++) begin rf0[i] = rf_m[i]; exp_rf[i] = rf_m[i]; end
    exp_psw = psw0;
    n = 0; a = sp0;
    if (!pop) begin
      if (m[31]) begin a -= 4; exp_addr[n] = a; exp_data[n] = psw0; exp_half[n] = 1'b0; n++; end
      for (int i = 30; i >= 0; i--)
        if (m[i]) begin a -= 4; exp_addr[n] = a; exp_data[n] = rf0[i]; exp_half[n] = 1'b0; n++; end
    end else begin
      for (int i = 0; i < 31; i++)
        if (m[i]) begin
          exp_addr[n] = a; exp_half[n] = 1'b0; exp_rf[i] = mem_m[a[11:2]]; a += 4; n++;
        end
      if (m[31]) begin
        exp_addr[n] = a; exp_half[n] = 1'b1;
        exp_psw = {psw0[31:16], mem_m[a[11:2]][15:0]}; a += 4; n++;
      end
    end
    exp_sp = a;
    log_n = 0;
    start = 1'b1; op_pop = pop; mask = m;
    cyc = 0; timed_out = 0;
    @(negedge clk);
    if (poke) begin mask = ~m; op_pop = ~pop; end
    else start = 1'b0;
    cyc = 1;
    while (!done && !timed_out) begin
      @(negedge clk); cyc++;
      if (cyc > 600) timed_out = 1;
    end
    start = 1'b0;
    chk(!timed_out, "R10 done reached", 32'(cyc), 32'd600);
    chk(busy == 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
    if (m == 0) begin
      chk(cyc == 1, "R7 zero mask done cycle", 32'(cyc), 32'd1);
      chk(log_n == 0 && sp_m == sp0, "R7 zero mask no transfer", sp_m, sp0);
    end
    chk(log_n == n, "R6 transfer count", 32'(log_n), 32'(n));
    bad_ord = 0;
    for (int k = 0; k < n && k < log_n; k++) begin
      if (log_addr[k] != exp_addr[k] || log_we[k] != !pop) bad_ord++;
      if (!pop && log_data[k] != exp_data[k]) bad_ord++;
      if (pop && log_half[k] != exp_half[k]) bad_ord++;
    end
    if (!pop) chk(bad_ord == 0, "R2 push order/data", 32'(bad_ord), 32'd0);
    else      chk(bad_ord == 0, "R3 pop order / R4 half flag", 32'(bad_ord), 32'd0);
    chk(sp_m == exp_sp, "R11 final stack pointer", sp_m, exp_sp);
    if (pop) begin
      bad_ord = 0;
      for (int i = 0; i < 31; i++) if (rf_m[i] != exp_rf[i]) bad_ord++;
      chk(bad_ord == 0, "R3 registers loaded", 32'(bad_ord), 32'd0);
      chk(psw_m == exp_psw, "R4 status word low half", psw_m, exp_psw);
    end
    if (poke) chk(bad_ord == 0 && sp_m == exp_sp, "R9 start ignored while busy", sp_m, exp_sp);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 31; i++) rf_m[i] = $urandom;
    for (int k = 0; k < 1024; k++) mem_m[k] = $urandom;
    psw_m = 32'hA5C3_1E2F;
    sp_m  = 32'h0000_0600;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R1 reset state",
        {29'd0, busy, done, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);

    run_op(1'b0, 32'h0000_0000, 1'b0, 1'b0);          // R7 zero mask push
    run_op(1'b1, 32'h0000_0000, 1'b0, 1'b1);          // R7 zero mask pop with held start
    run_op(1'b0, 32'h8000_0000, 1'b0, 1'b0);          // R2 status only
    run_op(1'b1, 32'h8000_0000, 1'b0, 1'b0);          // R4 status only
    run_op(1'b0, 32'h0000_0001, 1'b0, 1'b0);
    run_op(1'b1, 32'h4000_0000, 1'b1, 1'b0);          // R5 top register
    // Mirror: push everything, scramble, pop everything back
    run_op(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    for (int i = 0; i < 31; i++) rf_m[i] = $urandom;
    psw_m = $urandom;
    run_op(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);          // R9 held start at final handshake
    run_op(1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0);
    run_op(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0);

    for (int t = 0; t < 40; t++) begin
      logic [31:0] m;
      bit p;
      p = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 2))
        0: m = $urandom & $urandom;
        1: m = $urandom;
        default: m = $urandom | $urandom;
      endcase
      if (sp_m < 32'h300 || sp_m > 32'hA00) sp_m = 32'h600;
      run_op(p, m, p, $urandom_range(0, 3) == 0);
    end

    chk(hold_bad == 0, "R8 request held until ready", 32'(hold_bad), 32'd0);
    chk(rf_bad == 0, "R5 register write index", 32'(rf_bad), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule